// File: doc/BRIEF.md
# Shared Prescaler and Power-of-Two Tick Divider

This block turns one peripheral clock into five per-channel count-enable strobes for a multi-channel timer. Two 8-bit prescalers each divide the clock by their stored value plus one. The first prescaler serves channels 0 and 1, and the second serves channels 2, 3 and 4. After its prescaler, each channel has its own power-of-two divider, chosen by a 4-bit select code. A channel strobes once every (prescale ratio × divide ratio) clock cycles.

Software configures the block through a write-only register port with two word addresses. Address 0 holds both prescaler fields. Address 1 holds the five select codes. The select code gives log2 of the divide ratio minus a build-time base offset, and codes that would need a ratio above 16 give 16. Each output is a one-cycle pulse in the clock domain, not a derived clock. Each write restarts the counters it affects, so no shortened interval is issued after a change.

Top module: `tick_gen_top`

## Requirements
- R1: While reset is active, and on the first clock edge after it, every tick output is 0. Both prescaler fields and all select codes reset to 0.
- R2: A write to word address 0 loads prescaler A from data bits 7:0 and prescaler B from data bits 15:8. Data bits 31:16 are ignored.
- R3: A prescaler holding value P emits one boundary every P+1 clock cycles.
- R4: Channels 0 and 1 count boundaries of prescaler A. Channels 2, 3 and 4 count boundaries of prescaler B.
- R5: A write to word address 1 loads the select code of channel c from data bits 4c+3:4c, for c from 0 to 4.
- R6: The divide ratio is 2^(code + DIV_BASE), capped at 16. With the default DIV_BASE of 1, code 0 gives 2, code 1 gives 4, code 2 gives 8, and codes 3 to 15 give 16.
- R7: A tick is a one-cycle pulse. It rises on the clock edge after the cycle in which the channel's prescaler boundary meets the divider's last count. The steady period is (P+1) × ratio cycles.
- R8: A write to address 0 clears both prescaler counters. A prescaler boundary that falls in the same cycle as the write is discarded.
- R9: A write to address 1 clears every channel divider. No tick is issued on the edge of that write.
- R10: Writes to word addresses other than 0 and 1 change neither the configuration nor the tick pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word address of the write |
| cfg_wdata | input | 32 | Write data |
| tick | output | 5 | One count-enable strobe per channel |

## Verification
The counter-range assertions rely on select codes changing only through a write to address 1, which also restarts the dividers. They likewise rely on prescaler values changing only through a write to address 0, which clears the prescaler counters. The stimulus changes configuration only through the register port, with strobes driven away from the clock edge. This keeps every counter bound valid across reconfiguration. The stimulus then packs writes close together, including writes that land on prescaler boundaries, to test the restart and suppression rules.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Last divider count for a select code: ratio = 2^(code+base), capped.
  function automatic int div_last(input int code, input int base, input int max_log);
    int lg;
    lg = code + base;
    if (lg > max_log) lg = max_log;
    return (1 << lg) - 1;
  endfunction

  // Prescaler serving a channel: channels below the split use index 0.
  function automatic int group_of(input int ch, input int split);
    return (ch < split) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int NUM_PRE = 2,
  parameter int PRE_W = 8,
  parameter int NUM_CH = 5,
  parameter int SEL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [NUM_PRE*PRE_W-1:0]  pre_vals,
  output logic [NUM_CH*SEL_W-1:0]   sel_codes,
  output logic                      wr_pre,
  output logic                      wr_sel
);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(1);

  assign wr_pre = cfg_we && (cfg_addr == PRE_ADDR);
  assign wr_sel = cfg_we && (cfg_addr == SEL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_vals <= '0;
    end else if (wr_pre) begin
      pre_vals <= cfg_wdata[NUM_PRE*PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_codes <= '0;
    end else if (wr_sel) begin
      sel_codes <= cfg_wdata[NUM_CH*SEL_W-1:0];
    end
  end

  // R10: a write to any other address leaves the configuration alone
  a_r10_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_pre && !wr_sel) |=> ($stable(pre_vals) && $stable(sel_codes)));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] div_val,
  output logic             boundary
);
  logic [PRE_W-1:0] cnt;
  logic             at_end;

  assign at_end   = (cnt == div_val);
  assign boundary = at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the counter never runs past the programmed value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_val);

  // R8: a restart leaves the counter at zero
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int SEL_W = 4,
  parameter int MAX_LOG = 4,
  parameter int DIV_BASE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign last = CNT_W'(tick_pkg::div_last(int'(sel), DIV_BASE, MAX_LOG));
  assign wrap = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (pre_pulse) begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + 1'b1;
    end else begin
      tick <= 1'b0;
    end
  end

  // R6: count stays within the selected ratio
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R9: no tick on the edge of a select write
  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R7: every tick follows a prescaler boundary
  a_r7_tick_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(pre_pulse));
endmodule

// File: rtl/tick_gen_top.sv
module tick_gen_top #(
  parameter int NUM_CH = 5,
  parameter int PRE_W = 8,
  parameter int SEL_W = 4,
  parameter int MAX_LOG = 4,
  parameter int DIV_BASE = 1,
  parameter int GRP_SPLIT = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] tick
);
  localparam int NUM_PRE = 2;

  logic [NUM_PRE*PRE_W-1:0] pre_vals;
  logic [NUM_CH*SEL_W-1:0]  sel_codes;
  logic                     wr_pre;
  logic                     wr_sel;
  logic [NUM_PRE-1:0]       boundary;

  tick_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PRE(NUM_PRE),
    .PRE_W(PRE_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pre_vals(pre_vals), .sel_codes(sel_codes),
    .wr_pre(wr_pre), .wr_sel(wr_sel)
  );

  for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(wr_pre),
      .div_val(pre_vals[g*PRE_W +: PRE_W]), .boundary(boundary[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = tick_pkg::group_of(c, GRP_SPLIT);
    tick_divider #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG), .DIV_BASE(DIV_BASE)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(wr_sel), .pre_pulse(boundary[GRP]),
      .sel(sel_codes[c*SEL_W +: SEL_W]), .tick(tick[c])
    );
  end

  // R4: channels on the same prescaler with equal codes tick together
  a_r4_group_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_codes[0 +: SEL_W] == sel_codes[SEL_W +: SEL_W]) |-> (tick[0] == tick[1]));
endmodule

// File: tb/tick_gen_top_tb.sv
module tick_gen_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;
  localparam int BASE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH-1:0] tick;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  int pc[2];
  int prv[2];
  int dc[NCH];
  int sl[NCH];
  bit tk[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_gen_top #(.DIV_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick)
  );

  // Behavioural reference, stepped on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin pc[g] = 0; prv[g] = 0; end
      for (int c = 0; c < NCH; c++) begin dc[c] = 0; sl[c] = 0; tk[c] = 0; end
    end else begin
      bit w0, w1;
      bit pt[2];
      w0 = cfg_we && (cfg_addr == 2'd0);
      w1 = cfg_we && (cfg_addr == 2'd1);
      for (int g = 0; g < 2; g++) pt[g] = (pc[g] == prv[g]) && !w0;
      for (int c = 0; c < NCH; c++) begin
        int lg, r, g;
        g = (c < 2) ? 0 : 1;
        lg = sl[c] + BASE;
        if (lg > 4) lg = 4;
        r = 1 << lg;
        if (w1) begin
          dc[c] = 0; tk[c] = 0;
        end else if (pt[g]) begin
          tk[c] = (dc[c] == r - 1);
          dc[c] = tk[c] ? 0 : dc[c] + 1;
        end else begin
          tk[c] = 0;
        end
      end
      for (int g = 0; g < 2; g++) pc[g] = (w0 || pc[g] == prv[g]) ? 0 : pc[g] + 1;
      if (w0) begin prv[0] = int'(cfg_wdata[7:0]); prv[1] = int'(cfg_wdata[15:8]); end
      if (w1) for (int c = 0; c < NCH; c++) sl[c] = int'(cfg_wdata[4*c +: 4]);
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        bit exp_t;
        exp_t = rst_n ? tk[c] : 1'b0;
        compared++;
        if (tick[c] !== exp_t) begin
          mismatched++;
          $display("FAIL %s ch%0d t=%0t: tick=%0b expected=%0b", tag, c, $time, tick[c], exp_t);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R1 reset";
    idle(4);
    rst_n = 1'b1;
    tag = "R6 R7 default code0 ratio2";
    idle(40);
    tag = "R2 R3 R4 prescalers 2 and 3";
    wr(2'd0, 32'h0000_0302);
    idle(120);
    tag = "R5 R6 per-channel codes";
    wr(2'd1, 32'h0007_3210);
    idle(400);
    tag = "R2 upper data bits ignored";
    wr(2'd0, 32'hFFFF_0100);
    idle(200);
    tag = "R6 codes above range cap at 16";
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h000F_98CA);
    idle(120);
    tag = "R8 repeated prescaler writes";
    wr(2'd0, 32'h0000_0101);
    for (int i = 0; i < 6; i++) begin
      idle(i);
      wr(2'd0, 32'h0000_0201 + 32'(i));
    end
    idle(150);
    tag = "R9 repeated select writes";
    wr(2'd1, 32'h0000_0000);
    for (int i = 0; i < 6; i++) begin
      idle(i + 1);
      wr(2'd1, 32'h0001_0010 * 32'(i % 3));
    end
    idle(150);
    tag = "R10 writes to unused addresses";
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'h1234_5678);
    idle(100);
    tag = "R3 R7 wide prescaler";
    wr(2'd0, 32'h0000_0A13);
    wr(2'd1, 32'h0002_1003);
    idle(2000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule